// File: doc/BRIEF.md
# Storage Key Protection Tester

This block answers one question about a page: could an access that carries a given 4-bit access key fetch from the page, store into it, or neither? It returns the answer as a 2-bit condition code, the same encoding a protection-test instruction reports.

The caller supplies:
- a request strobe and a byte address;
- the test key;
- the outcomes of a store translation attempt and of a fetch translation attempt;
- two control enables: a storage-protection override and a fetch-protection override.

The block then works through a fixed sequence. It reads the page's storage key through a read-only key-array port, evaluates the store case, and falls back to a fetch case where needed. The test is side-effect free. No path exists by which the block could write a key, so the change bit is never set, even by the store check.

Translation itself happens outside the block. So do access-list checks and access-register handling. Their results arrive on the two translation-result inputs. Translation results use this code: 0 means success, 1 means protection exception, 2 or 3 means any other failure.

Top module: `skp_tester`

## Requirements
- R1: The storage key read from the array is 7 bits. Bits 6:3 are the access-control value and bit 2 is the fetch-protect flag. Bits 1:0 (reference, change) have no effect on the result.
- R2: A test key of 0 matches every access-control value.
- R3: A key mismatch is ignored when both hold: the storage-protection override enable is 1 and the access-control value is 9. When the enable is 0, value 9 is compared like any other.
- R4: If the store translation result is 0 and the keys match, the code is 0.
- R5: If the store translation result is 0 and the keys mismatch, the code is 2 when the page is fetch-protected and 1 otherwise.
- R6: If the store translation result is 1, the fetch result decides the code. A fetch result of 0 gives code 1, or code 2 when the page is fetch-protected and the keys mismatch. A fetch result of 1 gives code 2.
- R7: A store translation result of 2 or 3 gives code 3, whatever the fetch result is. A fetch result of 2 or 3 also gives code 3 when the fetch result is consulted.
- R8: The fetch-protect flag is treated as 0 when both hold: the fetch-protection override enable is 1 and the byte address is below 2048. Addresses at 2048 or above, including any address on a page other than page 0, keep the flag.
- R9: The timing is fixed. A request is sampled at a clock edge. One cycle later key_rd_o is high for exactly one cycle, with key_addr_o equal to the address shifted right by 12. The array returns key_rdata_i in the following cycle. cc_valid_o is high for exactly one cycle, three cycles after the edge that sampled the request.
- R10: All operands are captured when a request is accepted. Requests, and any changes of the inputs, have no effect while a test is in progress. A new request is accepted in the cycle that cc_valid_o is high.
- R11: After reset, cc_valid_o and key_rd_o are low and the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a test (accepted when idle) |
| test_key_i | input | 4 | Access key under test |
| addr_i | input | ADDR_W | Byte address of the tested location |
| st_res_i | input | 2 | Store translation result (0 ok, 1 protection, 2/3 other fault) |
| fe_res_i | input | 2 | Fetch translation result, same code |
| spo_en_i | input | 1 | Storage-protection override enable |
| fpo_en_i | input | 1 | Fetch-protection override enable |
| key_rdata_i | input | 7 | Storage key returned by the key array |
| key_rd_o | output | 1 | Key array read strobe |
| key_addr_o | output | ADDR_W-12 | Page index for the key read |
| cc_o | output | 2 | Condition code |
| cc_valid_o | output | 1 | Condition code valid, one cycle |

## Verification
The hardest situation to reach is one where several exemption rules overlap. Examples are a page with access-control 9 under the override that is also fetch-protected, and an address just at or below the 2048 boundary with the fetch override on. The directed stimulus places the test key, the stored key and the address on each side of those lines. The random phase then holds req_i high for long stretches while changing every operand and scrambling key_rdata_i outside its read window. This shows that only the captured operands and the read-window key reach the code.

// File: rtl/skp_pkg.sv
package skp_pkg;
  typedef logic [1:0] xl_t;
  localparam xl_t XL_OK   = 2'd0;
  localparam xl_t XL_PROT = 2'd1;

  typedef struct packed {
    logic [3:0] acc;
    logic       fp;
    logic       ref_b;
    logic       chg;
  } skey_t;

  typedef enum logic [1:0] {S_IDLE, S_KEY, S_STORE, S_FETCH} seq_e;
endpackage

// File: rtl/skp_key_cmp.sv
module skp_key_cmp #(
  parameter logic [3:0] OVR_KEY = 4'd9
) (
  input  logic [3:0] test_key_i,
  input  logic [3:0] acc_i,
  input  logic       fp_i,
  input  logic       spo_en_i,
  input  logic       fpo_hit_i,
  output logic       match_o,
  output logic       fprot_o
);
  always_comb begin
    match_o = (test_key_i == 4'd0) || (test_key_i == acc_i) ||
              (spo_en_i && (acc_i == OVR_KEY));
    fprot_o = fp_i && !fpo_hit_i;
  end
endmodule

// File: rtl/skp_cc_eval.sv
module skp_cc_eval
  import skp_pkg::*;
(
  input  xl_t        st_res_i,
  input  xl_t        fe_res_i,
  input  logic       match_i,
  input  logic       fprot_i,
  output logic [1:0] cc_o
);
  always_comb begin
    if (st_res_i == XL_OK) begin
      cc_o = match_i ? 2'd0 : (fprot_i ? 2'd2 : 2'd1);
    end else if (st_res_i == XL_PROT) begin
      // store refused: retry as fetch
      if (fe_res_i == XL_OK)        cc_o = (fprot_i && !match_i) ? 2'd2 : 2'd1;
      else if (fe_res_i == XL_PROT) cc_o = 2'd2;
      else                          cc_o = 2'd3;
    end else begin
      cc_o = 2'd3;
    end
  end
endmodule

// File: rtl/skp_seq.sv
module skp_seq
  import skp_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic accept_o,
  output logic key_rd_o,
  output logic key_lat_o,
  output logic fin_o
);
  seq_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      S_IDLE:  if (req_i) st_d = S_KEY;
      S_KEY:   st_d = S_STORE;
      S_STORE: st_d = S_FETCH;
      S_FETCH: st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign accept_o  = (st_q == S_IDLE) && req_i;
  assign key_rd_o  = (st_q == S_KEY);
  assign key_lat_o = (st_q == S_STORE);
  assign fin_o     = (st_q == S_FETCH);

  // R9
  key_rd_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rd_o |=> !key_rd_o);
  // R10
  busy_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rd_o |=> (key_lat_o && !accept_o));
endmodule

// File: rtl/skp_tester.sv
module skp_tester
  import skp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned PAGE_W  = 12,
  parameter int unsigned LOW_W   = 11,
  parameter logic [3:0]  OVR_KEY = 4'd9
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic [3:0]               test_key_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [1:0]               st_res_i,
  input  logic [1:0]               fe_res_i,
  input  logic                     spo_en_i,
  input  logic                     fpo_en_i,
  input  logic [6:0]               key_rdata_i,
  output logic                     key_rd_o,
  output logic [ADDR_W-PAGE_W-1:0] key_addr_o,
  output logic [1:0]               cc_o,
  output logic                     cc_valid_o
);
  localparam int unsigned PG_W = ADDR_W - PAGE_W;

  logic            accept, key_lat, fin;
  logic [3:0]      tk_q;
  logic [PG_W-1:0] page_q;
  logic            low_q, spo_q, fpo_q;
  xl_t             st_q, fe_q;
  skey_t           key_q;
  logic            match, fprot;
  logic [1:0]      cc_d;
  logic            unused_bits;

  assign unused_bits = ^{addr_i[LOW_W-1:0], key_q.ref_b, key_q.chg};

  skp_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .accept_o (accept),
    .key_rd_o (key_rd_o),
    .key_lat_o(key_lat),
    .fin_o    (fin)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tk_q   <= '0;
      page_q <= '0;
      low_q  <= 1'b0;
      spo_q  <= 1'b0;
      fpo_q  <= 1'b0;
      st_q   <= XL_OK;
      fe_q   <= XL_OK;
    end else if (accept) begin
      tk_q   <= test_key_i;
      page_q <= addr_i[ADDR_W-1:PAGE_W];
      low_q  <= (addr_i[ADDR_W-1:LOW_W] == '0);
      spo_q  <= spo_en_i;
      fpo_q  <= fpo_en_i;
      st_q   <= st_res_i;
      fe_q   <= fe_res_i;
    end
  end

  // key arrives the cycle after the read strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      key_q <= '0;
    else if (key_lat) key_q <= skey_t'(key_rdata_i);
  end

  skp_key_cmp #(.OVR_KEY(OVR_KEY)) u_cmp (
    .test_key_i(tk_q),
    .acc_i     (key_q.acc),
    .fp_i      (key_q.fp),
    .spo_en_i  (spo_q),
    .fpo_hit_i (fpo_q && low_q),
    .match_o   (match),
    .fprot_o   (fprot)
  );

  skp_cc_eval u_eval (
    .st_res_i(st_q),
    .fe_res_i(fe_q),
    .match_i (match),
    .fprot_i (fprot),
    .cc_o    (cc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cc_o       <= 2'd0;
      cc_valid_o <= 1'b0;
    end else begin
      cc_valid_o <= fin;
      if (fin) cc_o <= cc_d;
    end
  end

  assign key_addr_o = page_q;

  // R9
  valid_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rd_o |-> ##3 cc_valid_o);
  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_valid_o |=> !cc_valid_o);
  // R7
  st_fault_cc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_valid_o && st_q[1]) |-> (cc_o == 2'd3));
  // R2
  key0_cc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_valid_o && tk_q == 4'd0 && st_q == XL_OK) |-> (cc_o == 2'd0));
  // R10
  hold_ops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_rd_o |=> ($stable(tk_q) && $stable(st_q) && $stable(fe_q)));
endmodule

// File: tb/tb_skp_tester.sv
module tb_skp_tester;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  test_key_i = '0;
  logic [31:0] addr_i = '0;
  logic [1:0]  st_res_i = '0, fe_res_i = '0;
  logic        spo_en_i = 1'b0, fpo_en_i = 1'b0;
  logic [6:0]  key_rdata_i = '0;
  logic        key_rd_o;
  logic [19:0] key_addr_o;
  logic [1:0]  cc_o;
  logic        cc_valid_o;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [6:0] keymem [16];
  int age = -1;
  logic [1:0] exp_cc;
  string exp_tag;
  logic [19:0] exp_page;

  always #10 clk_i = ~clk_i;

  skp_tester dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .test_key_i(test_key_i),
    .addr_i(addr_i), .st_res_i(st_res_i), .fe_res_i(fe_res_i),
    .spo_en_i(spo_en_i), .fpo_en_i(fpo_en_i), .key_rdata_i(key_rdata_i),
    .key_rd_o(key_rd_o), .key_addr_o(key_addr_o), .cc_o(cc_o),
    .cc_valid_o(cc_valid_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0] tk, input logic [6:0] key,
      input logic [31:0] a, input logic [1:0] st, input logic [1:0] fe,
      input bit spo, input bit fpo, output logic [1:0] cc, output string tag);
    logic [3:0] acc = key[6:3];
    bit f = key[2];
    bit m;
    tag = "R1";
    if (fpo && a < 32'd2048) begin
      if (f) tag = {tag, " R8"};
      f = 0;
    end
    m = (tk == 0) || (tk == acc) || (spo && acc == 4'd9);
    if (tk == 0) tag = {tag, " R2"};
    if (acc == 4'd9 && tk != 0 && tk != 9) tag = {tag, " R3"};
    if (st >= 2)       begin cc = 3; tag = {tag, " R7"}; end
    else if (st == 0)  begin cc = m ? 2'd0 : (f ? 2'd2 : 2'd1); tag = {tag, m ? " R4" : " R5"}; end
    else if (fe >= 2)  begin cc = 3; tag = {tag, " R7 R6"}; end
    else if (fe == 1)  begin cc = 2; tag = {tag, " R6"}; end
    else               begin cc = (f && !m) ? 2'd2 : 2'd1; tag = {tag, " R6"}; end
  endfunction

  // one cycle: check outputs, then drive, then advance the model
  task automatic step(input bit r, input logic [3:0] tk, input logic [31:0] a,
      input logic [1:0] st, input logic [1:0] fe, input bit spo, input bit fpo);
    @(negedge clk_i);
    chk(key_rd_o == (age == 0), "R9 R10 key_rd_o", int'(key_rd_o), int'(age == 0));
    if (age == 0) begin
      chk(key_addr_o == exp_page, "R9 key_addr_o", int'(key_addr_o), int'(exp_page));
      key_rdata_i = keymem[exp_page[3:0]];
    end else if (age != 1) begin
      key_rdata_i = 7'($urandom);
    end
    chk(cc_valid_o == (age == 3), "R9 R10 cc_valid_o", int'(cc_valid_o), int'(age == 3));
    if (age == 3) chk(cc_o == exp_cc, exp_tag, int'(cc_o), int'(exp_cc));
    req_i = r; test_key_i = tk; addr_i = a; st_res_i = st; fe_res_i = fe;
    spo_en_i = spo; fpo_en_i = fpo;
    if ((age < 0 || age == 3) && r) begin
      age = 0;
      exp_page = a[31:12];
      model(tk, keymem[a[15:12]], a, st, fe, spo, fpo, exp_cc, exp_tag);
    end else if (age >= 0 && age < 3) age++;
    else age = -1;
  endtask

  task automatic one(input logic [3:0] tk, input logic [31:0] a, input logic [1:0] st,
      input logic [1:0] fe, input bit spo, input bit fpo);
    step(1, tk, a, st, fe, spo, fpo);
    // scramble operands while busy (R10)
    for (int i = 0; i < 3; i++)
      step(1'($urandom), 4'($urandom), {16'd0, 16'($urandom)}, 2'($urandom), 2'($urandom),
           1'($urandom), 1'($urandom));
    step(0, '0, '0, '0, '0, 0, 0);
    step(0, '0, '0, '0, '0, 0, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) keymem[i] = 7'($urandom);
    repeat (2) @(negedge clk_i);
    // R11
    chk(cc_valid_o == 0 && key_rd_o == 0, "R11 reset", int'({cc_valid_o, key_rd_o}), 0);
    rst_ni = 1'b1;
    step(0, '0, '0, '0, '0, 0, 0);
    chk(cc_valid_o == 0 && key_rd_o == 0, "R11 idle after reset", int'({cc_valid_o, key_rd_o}), 0);

    keymem[1] = {4'd5, 1'b1, 2'b11};   // acc 5, fetch-protected, ref/chg set
    keymem[2] = {4'd5, 1'b0, 2'b00};
    keymem[3] = {4'd9, 1'b1, 2'b01};
    keymem[0] = {4'd6, 1'b1, 2'b10};
    one(4'd0, 32'h1000, 2'd0, 2'd0, 0, 0);   // R2
    one(4'd5, 32'h1004, 2'd0, 2'd0, 0, 0);   // R4
    one(4'd4, 32'h1008, 2'd0, 2'd0, 0, 0);   // R5 fp -> 2
    one(4'd4, 32'h2008, 2'd0, 2'd0, 0, 0);   // R5 -> 1
    one(4'd4, 32'h3000, 2'd0, 2'd0, 1, 0);   // R3 override
    one(4'd4, 32'h3000, 2'd0, 2'd0, 0, 0);   // R3 no override
    one(4'd4, 32'h3000, 2'd1, 2'd0, 1, 0);   // R3 + R6
    one(4'd4, 32'h1000, 2'd1, 2'd0, 0, 0);   // R6 -> 2
    one(4'd5, 32'h1000, 2'd1, 2'd0, 0, 0);   // R6 -> 1
    one(4'd5, 32'h1000, 2'd1, 2'd1, 0, 0);   // R6 -> 2
    one(4'd5, 32'h1000, 2'd2, 2'd0, 0, 0);   // R7
    one(4'd5, 32'h1000, 2'd1, 2'd3, 0, 0);   // R7
    one(4'd7, 32'h0000_07FF, 2'd0, 2'd0, 0, 1); // R8 inside
    one(4'd7, 32'h0000_0800, 2'd0, 2'd0, 0, 1); // R8 boundary
    one(4'd7, 32'h0000_0010, 2'd0, 2'd0, 0, 0); // R8 disabled
    keymem[1] = {4'd5, 1'b1, 2'b00};
    one(4'd4, 32'h1008, 2'd0, 2'd0, 0, 0);   // R1 ref/chg ignored

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] a = {16'd0, 4'($urandom_range(0, 3)), 12'($urandom)};
      step(($urandom % 3) != 0, ($urandom % 4 == 0) ? 4'd9 : 4'($urandom % 8), a,
           2'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
    end
    repeat (5) step(0, '0, '0, '0, '0, 0, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL R9 watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule